// File: doc/BRIEF.md
# Converter Power-Up Sequencer with Frame Clock Ratio Detection

This block takes an audio converter from reset to normal operation. While its active-low reset is asserted, the block holds a power-down state. After reset is released, it enables the control port and captures the hardware configuration pins.

When the master clock is reported valid, the block powers the conversion paths. The analog outputs stay clamped at their quiescent level. The block then synchronises the frame clock into the master clock domain and counts master clock cycles between two consecutive frame clock rising edges. It matches that count against the supported clock ratios.

After a successful match, the block waits a parameterised number of frame periods before it releases the clamp and signals ready. If the frame clock stalls, or the master clock becomes invalid, the outputs are clamped again and detection restarts.

Top module: `codec_pwrup_seq`

## Requirements
- R1: While `rst_n` is low: `pwr_down`=1, `ctrl_en`=0, `clamp`=1, `ready`=0, `ratio_code`=0 and `mode_latched`=0.
- R2: `ctrl_en` goes high at the first `mclk` rising edge after `rst_n` goes high and stays high until the next reset. `pwr_down` stays high while `mclk_ok` is low.
- R3: `mode_pins` is captured into `mode_latched` at the first `mclk` edge after reset release. Later changes of `mode_pins` have no effect on it.
- R4: When `mclk_ok` is sampled low, the next state has `pwr_down`=1, `clamp`=1, `ready`=0 and `ratio_code`=0. When `mclk_ok` is sampled high, `pwr_down` falls one edge later while `clamp` stays high.
- R5: The frame period is the number of `mclk` cycles between two consecutive synchronised `lrck` rising edges. The ratio code is set to 1 for 128, 2 for 256, 3 for 384, 4 for 512, 5 for 768 and 6 for 1024, each within ±TOL cycles (TOL=2 by default).
- R6: A period that matches no supported ratio leaves `ratio_code`=0 and `clamp`=1, and the next period is measured again. A later valid period is then detected without a reset.
- R7: `ready` rises and `clamp` falls only after UNMUTE_PERIODS further `lrck` rising edges following detection. `ready`=1 always implies `clamp`=0 and a nonzero `ratio_code`.
- R8: If more than STALL_LIMIT `mclk` cycles pass with no `lrck` rising edge, the block clamps, drops `ready`, clears `ratio_code` and restarts detection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| mclk_ok | input | 1 | Master clock is stable and valid |
| lrck | input | 1 | Frame clock, asynchronous to mclk |
| mode_pins | input | MODE_W | Hardware configuration straps |
| pwr_down | output | 1 | Conversion paths powered down |
| ctrl_en | output | 1 | Control port accessible |
| mode_latched | output | MODE_W | Straps captured at reset release |
| clamp | output | 1 | Analog outputs held at quiescent level |
| ratio_code | output | 3 | Detected clock ratio code (0 = none) |
| ready | output | 1 | Normal operation |

## Verification
The bench builds the block with UNMUTE_PERIODS=4, so that the unmute wait completes in a few frames. It keeps STALL_LIMIT at 2048 and TOL at 2. This setting lets every supported ratio, including 1024, run through detection, the delay and release within a short run. The stall watchdog can then be driven just below and just above its limit. The tolerance edges (126 and 130 cycles) and an unsupported period (200 cycles) exercise the classification window and the re-measure path.

// File: rtl/codec_pwrup_seq.sv
module codec_pwrup_seq #(
  parameter int MODE_W         = 4,
  parameter int UNMUTE_PERIODS = 2000,
  parameter int STALL_LIMIT    = 2048,
  parameter int TOL            = 2
) (
  input  logic              mclk,
  input  logic              rst_n,
  input  logic              mclk_ok,
  input  logic              lrck,
  input  logic [MODE_W-1:0] mode_pins,
  output logic              pwr_down,
  output logic              ctrl_en,
  output logic [MODE_W-1:0] mode_latched,
  output logic              clamp,
  output logic [2:0]        ratio_code,
  output logic              ready
);

  localparam int CNT_W = $clog2(STALL_LIMIT + 2);
  localparam int PER_W = (UNMUTE_PERIODS > 1) ? $clog2(UNMUTE_PERIODS) : 1;

  typedef enum logic [1:0] {S_OFF, S_MEAS, S_HOLD, S_RUN} st_t;

  st_t              st;
  logic [2:0]       lr_sync;
  logic [CNT_W-1:0] cnt;
  logic [PER_W-1:0] per;
  logic             armed;
  logic             cap;
  logic [MODE_W-1:0] mode_q;
  logic [2:0]       ratio_q;
  logic [2:0]       code;
  logic             rise;
  logic             stall;

  function automatic int nominal(input int idx);
    case (idx)
      1: return 128;
      2: return 256;
      3: return 384;
      4: return 512;
      5: return 768;
      default: return 1024;
    endcase
  endfunction

  assign rise  = lr_sync[1] & ~lr_sync[2];
  assign stall = (st != S_OFF) && (int'(cnt) > STALL_LIMIT);

  always_comb begin
    code = 3'd0;
    for (int i = 1; i <= 6; i++)
      if (int'(cnt) >= nominal(i) - TOL && int'(cnt) <= nominal(i) + TOL)
        code = 3'(i);
  end

  always_ff @(posedge mclk or negedge rst_n)
    if (!rst_n) lr_sync <= '0;
    else        lr_sync <= {lr_sync[1:0], lrck};

  always_ff @(posedge mclk or negedge rst_n)
    if (!rst_n) begin
      cap    <= 1'b0;
      mode_q <= '0;
    end else if (!cap) begin
      cap    <= 1'b1;
      mode_q <= mode_pins;
    end

  always_ff @(posedge mclk or negedge rst_n)
    if (!rst_n)                cnt <= '0;
    else if (st == S_OFF)      cnt <= '0;
    else if (rise)             cnt <= CNT_W'(1);
    else if (cnt != '1)        cnt <= cnt + 1'b1;

  always_ff @(posedge mclk or negedge rst_n)
    if (!rst_n) begin
      st      <= S_OFF;
      armed   <= 1'b0;
      ratio_q <= '0;
      per     <= '0;
    end else if (!mclk_ok) begin
      st      <= S_OFF;
      armed   <= 1'b0;
      ratio_q <= '0;
    end else if (st == S_OFF) begin
      st    <= S_MEAS;
      armed <= 1'b0;
    end else if (stall) begin
      st      <= S_MEAS;
      armed   <= 1'b0;
      ratio_q <= '0;
    end else if (rise) begin
      case (st)
        S_MEAS:
          if (!armed) armed <= 1'b1;
          else if (code != 3'd0) begin
            ratio_q <= code;
            per     <= '0;
            st      <= S_HOLD;
          end
        S_HOLD:
          if (int'(per) == UNMUTE_PERIODS - 1) st <= S_RUN;
          else per <= per + 1'b1;
        default: ;
      endcase
    end

  assign pwr_down     = (st == S_OFF);
  assign clamp        = (st != S_RUN);
  assign ready        = (st == S_RUN);
  assign ratio_code   = ratio_q;
  assign ctrl_en      = cap;
  assign mode_latched = mode_q;

  a_r2_ctrl_sticky: assert property (@(posedge mclk) disable iff (!rst_n)
    ctrl_en |=> ctrl_en);
  a_r3_mode_frozen: assert property (@(posedge mclk) disable iff (!rst_n)
    ctrl_en |=> $stable(mode_latched));
  a_r4_clock_loss: assert property (@(posedge mclk) disable iff (!rst_n)
    !mclk_ok |=> (pwr_down && clamp && ratio_code == 3'd0));
  a_r5_code_range: assert property (@(posedge mclk) disable iff (!rst_n)
    ratio_code <= 3'd6);
  a_r7_ready_valid: assert property (@(posedge mclk) disable iff (!rst_n)
    ready |-> (!clamp && ratio_code != 3'd0));
  a_r8_stall_clamps: assert property (@(posedge mclk) disable iff (!rst_n)
    (mclk_ok && int'(cnt) > STALL_LIMIT) |=> (clamp && ratio_code == 3'd0));

endmodule

// File: tb/codec_pwrup_seq_tb.sv
module codec_pwrup_seq_tb;
  localparam int PERIOD = 10;
  localparam int MW = 4;

  logic mclk = 1'b0;
  logic rst_n, mclk_ok, lrck;
  logic [MW-1:0] mode_pins;
  logic pwr_down, ctrl_en, clamp, ready;
  logic [MW-1:0] mode_latched;
  logic [2:0] ratio_code;

  int checks = 0, errors = 0;
  bit lr_run = 0;
  int lr_div = 128;
  int lr_cnt = 0;

  localparam int NV = 9;
  localparam int VEC [NV][2] = '{
    '{128, 1}, '{256, 2}, '{384, 3}, '{512, 4}, '{768, 5},
    '{1024, 6}, '{130, 1}, '{126, 1}, '{200, 0}};

  codec_pwrup_seq #(.MODE_W(MW), .UNMUTE_PERIODS(4), .STALL_LIMIT(2048), .TOL(2)) u_dut (
    .mclk(mclk), .rst_n(rst_n), .mclk_ok(mclk_ok), .lrck(lrck), .mode_pins(mode_pins),
    .pwr_down(pwr_down), .ctrl_en(ctrl_en), .mode_latched(mode_latched),
    .clamp(clamp), .ratio_code(ratio_code), .ready(ready));

  always #(PERIOD/2) mclk = ~mclk;

  always @(negedge mclk) begin
    if (!lr_run) begin
      lrck   <= 1'b0;
      lr_cnt <= 0;
    end else if (lr_cnt + 1 >= lr_div / 2) begin
      lrck   <= ~lrck;
      lr_cnt <= 0;
    end else lr_cnt <= lr_cnt + 1;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge mclk);
  endtask

  task automatic restart();
    lr_run  = 0;
    rst_n   = 0;
    mclk_ok = 0;
    cyc(3);
    rst_n   = 1;
    mclk_ok = 1;
    cyc(2);
  endtask

  initial begin
    #(PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 0; mclk_ok = 0; mode_pins = 4'hA;
    cyc(5);
    chk("R1 pwr_down", pwr_down, 1);
    chk("R1 ctrl_en", ctrl_en, 0);
    chk("R1 clamp", clamp, 1);
    chk("R1 ready", ready, 0);
    chk("R1 ratio", ratio_code, 0);
    chk("R1 mode", mode_latched, 0);
    rst_n = 1;
    cyc(1);
    chk("R2 ctrl_en", ctrl_en, 1);
    chk("R3 mode captured", mode_latched, 4'hA);
    mode_pins = 4'h5;
    cyc(3);
    chk("R3 mode ignored", mode_latched, 4'hA);
    chk("R2 pwr_down no clock", pwr_down, 1);
    mclk_ok = 1;
    cyc(1);
    chk("R4 pwr_down", pwr_down, 0);
    chk("R4 clamp", clamp, 1);

    for (int v = 0; v < NV; v++) begin
      restart();
      lr_div = VEC[v][0];
      lr_run = 1;
      cyc(4 * lr_div);
      chk("R5 ratio", ratio_code, VEC[v][1]);
      chk("R7 clamp held during delay", clamp, 1);
      cyc(4 * lr_div);
      chk("R7 ready", ready, VEC[v][1] != 0);
      chk("R6 R7 clamp", clamp, VEC[v][1] == 0);
      chk("R5 ratio kept", ratio_code, VEC[v][1]);
    end

    lr_div = 256;
    cyc(8 * 256);
    chk("R6 remeasure ratio", ratio_code, 2);
    chk("R6 remeasure ready", ready, 1);

    lr_run = 0;
    cyc(1700);
    chk("R8 below limit", ready, 1);
    cyc(500);
    chk("R8 stall ready", ready, 0);
    chk("R8 stall clamp", clamp, 1);
    chk("R8 stall ratio", ratio_code, 0);
    lr_div = 512;
    lr_run = 1;
    cyc(8 * 512);
    chk("R8 relock ratio", ratio_code, 4);
    chk("R8 relock ready", ready, 1);

    mclk_ok = 0;
    cyc(1);
    chk("R4 loss pwr_down", pwr_down, 1);
    chk("R4 loss clamp", clamp, 1);
    chk("R4 loss ratio", ratio_code, 0);
    mclk_ok = 1;
    cyc(8 * 512);
    chk("R4 recover ratio", ratio_code, 4);
    chk("R4 recover ready", ready, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule